// File: doc/BRIEF.md
# Card-Bus Clock Divider

This block turns a fast peripheral clock into the slower clock of a card bus. Software writes a control word. One bit of that word turns the clock on. A 4-bit code in the word picks a division of two to the power (code + 1), so the ratio runs from /2 up to /512. A further all-ones code asks for the undivided peripheral clock. That code is honoured only when the bypass-support strap input is high. Any other code is refused: the ratio in use stays as it was and the valid flag drops.

The divided clock leaves the block in two forms. `clk_div_o` is a registered square wave with a 50% duty cycle. `clk_en_o` is a one-cycle enable pulse, given once per divided period. Software typically runs at /256 while the card is being identified and moves to /4 for data transfer, so the ratio can be changed while the clock is running. A new ratio is applied only at a point where the output is low, and the high phase already in progress always runs to its full length, so no runt pulse appears.

The core is a four-state machine:
- `ST_OFF`: clock stopped.
- `ST_LOW`: low half-period.
- `ST_HIGH`: high half-period.
- `ST_BYP`: undivided bypass.

Its transitions are:
- OFF→LOW or OFF→BYP: the enable bit is seen. The stored code is loaded as it does so.
- LOW→HIGH: the half-period counter wraps.
- LOW→OFF: the enable bit is cleared.
- HIGH→LOW or HIGH→BYP: the counter wraps and the stored code is loaded.
- HIGH→OFF: the counter wraps with the enable bit cleared.
- BYP→LOW: a divided code is stored. It is loaded as the state changes.
- BYP→OFF: the enable bit is cleared.

Top module: `cardclk_div`

## Requirements
- R1: After reset, or while the enable bit has never been written to 1, `clk_div_o` and `clk_en_o` are 0 and `ratio_ok_o` is 1.
- R2: With an accepted code c in 0..8, `clk_div_o` is high for exactly 2^c cycles and low for exactly 2^c cycles. The period is therefore 2^(c+1) cycles.
- R3: `clk_en_o` pulses exactly once per divided period. The pulse falls in the first cycle in which `clk_div_o` is high.
- R4: A write takes the ratio code from bits [19:16] and the enable from bit 24. All other bits are ignored. The word 0x01072FFF gives /256 (128-cycle half-periods) and the word 0x01012FFF gives /4 (2-cycle half-periods).
- R5: Code 4'b1111 written while `bypass_ok_i` is 1 selects bypass. In bypass `clk_en_o` is 1 in every cycle and `clk_div_o` stays 0.
- R6: Codes 4'b1001 to 4'b1110 are refused, and so is 4'b1111 written while `bypass_ok_i` is 0. A refused code sets `ratio_ok_o` to 0 and leaves the running ratio unchanged.
- R7: A write with an accepted code sets `ratio_ok_o` to 1 in the cycle after the write.
- R8: A ratio written while `clk_div_o` is high takes effect only after that high phase has completed at the old length. The next low phase already uses the new ratio.
- R9: Clearing the enable bit lets a high phase in progress complete. The output then stays low with no enable pulses until the enable bit is set again. Setting it again restarts the clock at the stored ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 32 | Control word. Bit 24 is the enable; bits [19:16] are the ratio code |
| bypass_ok_i | input | 1 | Strap: 1 allows the undivided bypass code |
| clk_en_o | output | 1 | One-cycle enable pulse per divided period; held high in bypass |
| clk_div_o | output | 1 | Divided clock with a 50% duty cycle |
| ratio_ok_o | output | 1 | 1 when the last written code was accepted |

## Verification
The bench goes after four corner cases.

The first is a ratio change written partway through a /512 high phase. A design that switched at once would cut that phase short of 256 cycles and emit a runt pulse.

The second is the refused codes, including the bypass code with the strap low. A design that stored them would change the period or freeze the output, and the next measured half-period would not match the kept ratio.

The third is clearing the enable mid-high. A design that stopped at once would truncate the high phase; one that ignored the clear would keep pulsing `clk_en_o`.

The fourth is the extremes, /2 and /512, together with entering and leaving bypass. Off-by-one counting errors show up there as half-periods one cycle long or short, or as a missing or doubled enable pulse.

// File: rtl/cardclk_div_pkg.sv
package cardclk_div_pkg;

    // Divider state machine encoding
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_BYP  = 2'd3
    } div_state_e;

endpackage

// File: rtl/cardclk_div_cfg.sv
module cardclk_div_cfg #(
    parameter int DATA_W   = 32,
    parameter int CODE_W   = 4,
    parameter int CODE_LSB = 16,
    parameter int EN_BIT   = 24,
    parameter int MAX_CODE = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              strap_i,
    output logic              en_o,
    output logic [CODE_W-1:0] code_o,
    output logic              ok_o
);

    localparam logic [CODE_W-1:0] BYP_CODE = '1;
    localparam logic [DATA_W-1:0] USED_MASK =
        (DATA_W'(1) << EN_BIT) | (DATA_W'((1 << CODE_W) - 1) << CODE_LSB);

    logic [CODE_W-1:0] field_w;
    logic              legal_w;
    logic              unused_wbits;

    assign field_w      = wdata_i[CODE_LSB +: CODE_W];
    assign legal_w      = (field_w <= CODE_W'(MAX_CODE)) ||
                          ((field_w == BYP_CODE) && strap_i);
    assign unused_wbits = ^(wdata_i & ~USED_MASK);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_o   <= 1'b0;
            code_o <= '0;
            ok_o   <= 1'b1;
        end else if (we_i) begin
            en_o <= wdata_i[EN_BIT];
            ok_o <= legal_w;
            if (legal_w) begin
                code_o <= field_w;
            end
        end
    end

endmodule

// File: rtl/cardclk_div_halfcnt.sv
module cardclk_div_halfcnt #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8,
    parameter int CNT_W    = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              wrap_o,
    output logic              zero_o,
    output logic [CNT_W-1:0]  cnt_o
);

    logic [CNT_W-1:0] limit_w;
    logic [CNT_W-1:0] cnt_q;

    // Half-period minus one for the selected power of two
    always_comb begin
        if (code_i <= CODE_W'(MAX_CODE)) begin
            limit_w = (CNT_W'(1) << code_i) - CNT_W'(1);
        end else begin
            limit_w = '0;
        end
    end

    assign wrap_o = (cnt_q == limit_w);
    assign zero_o = (cnt_q == '0);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i || wrap_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/cardclk_div_fsm.sv
module cardclk_div_fsm
    import cardclk_div_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [CODE_W-1:0] pend_code_i,
    input  logic              wrap_i,
    input  logic              zero_i,
    output div_state_e        state_o,
    output logic [CODE_W-1:0] act_code_o,
    output logic              cnt_clr_o,
    output logic              div_clk_o,
    output logic              tick_o
);

    localparam logic [CODE_W-1:0] BYP_CODE = '1;

    div_state_e        state_q, state_d;
    logic [CODE_W-1:0] act_q, act_d;
    logic              pend_byp_w;

    assign pend_byp_w = (pend_code_i == BYP_CODE);

    // Next-state and ratio-load decision
    always_comb begin
        state_d = state_q;
        act_d   = act_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_i) begin
                    act_d   = pend_code_i;
                    state_d = pend_byp_w ? ST_BYP : ST_LOW;
                end
            end
            ST_LOW: begin
                if (!en_i) begin
                    state_d = ST_OFF;
                end else if (wrap_i) begin
                    state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (wrap_i) begin
                    if (!en_i) begin
                        state_d = ST_OFF;
                    end else begin
                        act_d   = pend_code_i;
                        state_d = pend_byp_w ? ST_BYP : ST_LOW;
                    end
                end
            end
            ST_BYP: begin
                if (!en_i) begin
                    state_d = ST_OFF;
                end else if (!pend_byp_w) begin
                    act_d   = pend_code_i;
                    state_d = ST_LOW;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            act_q   <= '0;
        end else begin
            state_q <= state_d;
            act_q   <= act_d;
        end
    end

    // Outputs decoded from registered state only
    always_comb begin
        div_clk_o = (state_q == ST_HIGH);
        tick_o    = ((state_q == ST_HIGH) && zero_i) || (state_q == ST_BYP);
        cnt_clr_o = (state_q == ST_OFF) || (state_q == ST_BYP);
    end

    assign state_o    = state_q;
    assign act_code_o = act_q;

endmodule

// File: rtl/cardclk_div.sv
module cardclk_div
    import cardclk_div_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CODE_W   = 4,
    parameter int CODE_LSB = 16,
    parameter int EN_BIT   = 24,
    parameter int MAX_CODE = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              bypass_ok_i,
    output logic              clk_en_o,
    output logic              clk_div_o,
    output logic              ratio_ok_o
);

    localparam int CNT_W = MAX_CODE + 1;

    logic              en_w;
    logic [CODE_W-1:0] pend_code_w;
    logic [CODE_W-1:0] act_code_w;
    logic              wrap_w;
    logic              zero_w;
    logic              cnt_clr_w;
    logic [CNT_W-1:0]  cnt_w;
    div_state_e        state_w;

    cardclk_div_cfg #(
        .DATA_W   (DATA_W),
        .CODE_W   (CODE_W),
        .CODE_LSB (CODE_LSB),
        .EN_BIT   (EN_BIT),
        .MAX_CODE (MAX_CODE)
    ) u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .strap_i (bypass_ok_i),
        .en_o    (en_w),
        .code_o  (pend_code_w),
        .ok_o    (ratio_ok_o)
    );

    cardclk_div_halfcnt #(
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE),
        .CNT_W    (CNT_W)
    ) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cnt_clr_w),
        .code_i (act_code_w),
        .wrap_o (wrap_w),
        .zero_o (zero_w),
        .cnt_o  (cnt_w)
    );

    cardclk_div_fsm #(
        .CODE_W (CODE_W)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_w),
        .pend_code_i (pend_code_w),
        .wrap_i      (wrap_w),
        .zero_i      (zero_w),
        .state_o     (state_w),
        .act_code_o  (act_code_w),
        .cnt_clr_o   (cnt_clr_w),
        .div_clk_o   (clk_div_o),
        .tick_o      (clk_en_o)
    );

endmodule

// File: rtl/cardclk_div_chk.sv
module cardclk_div_chk
    import cardclk_div_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CODE_W   = 4,
    parameter int CODE_LSB = 16,
    parameter int MAX_CODE = 8,
    parameter int CNT_W    = 9
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cfg_we_i,
    input logic [DATA_W-1:0] cfg_wdata_i,
    input logic              bypass_ok_i,
    input logic              clk_en_o,
    input logic              clk_div_o,
    input logic              ratio_ok_o,
    input div_state_e        state_i,
    input logic [CODE_W-1:0] act_code_i,
    input logic [CNT_W-1:0]  cnt_i
);

    logic [CODE_W-1:0] wcode;
    logic              w_accept;
    logic [CNT_W-1:0]  bound;
    logic              unused_chk;

    assign wcode      = cfg_wdata_i[CODE_LSB +: CODE_W];
    assign w_accept   = (wcode <= CODE_W'(MAX_CODE)) || ((&wcode) && bypass_ok_i);
    assign unused_chk = ^cfg_wdata_i;

    always_comb begin
        bound = '0;
        for (int i = 0; i <= MAX_CODE; i++) begin
            if (act_code_i == CODE_W'(i)) begin
                bound = CNT_W'((1 << i) - 1);
            end
        end
    end

    // R2: the half-period counter never runs past the selected length
    assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_LOW || state_i == ST_HIGH) |-> (cnt_i <= bound));

    // R3: every rising edge of the divided clock carries the enable pulse
    assert_tick_on_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_div_o) |-> clk_en_o);

    // R3: outside bypass the pulse only appears while the clock is high
    assert_tick_in_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_en_o && state_i != ST_BYP) |-> clk_div_o);

    // R5: bypass drives the enable continuously and keeps the clock low
    assert_bypass_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_BYP) |-> (clk_en_o && !clk_div_o));

    // R6: a refused code drops the valid flag
    assert_refused_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && !w_accept) |=> !ratio_ok_o);

    // R7: an accepted code raises the valid flag
    assert_accepted_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && w_accept) |=> ratio_ok_o);

    // R8: the running ratio only changes while the output is low
    assert_switch_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(act_code_i) |-> !clk_div_o);

    // R9: the stopped state is silent
    assert_off_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_OFF) |-> (!clk_div_o && !clk_en_o));

endmodule

bind cardclk_div cardclk_div_chk #(
    .DATA_W   (DATA_W),
    .CODE_W   (CODE_W),
    .CODE_LSB (CODE_LSB),
    .MAX_CODE (MAX_CODE),
    .CNT_W    (CNT_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .bypass_ok_i (bypass_ok_i),
    .clk_en_o    (clk_en_o),
    .clk_div_o   (clk_div_o),
    .ratio_ok_o  (ratio_ok_o),
    .state_i     (state_w),
    .act_code_i  (act_code_w),
    .cnt_i       (cnt_w)
);

// File: tb/test_cardclk_div.sv
`timescale 1ns/1ps
module test_cardclk_div;

    typedef struct packed {
        logic [31:0] wd;
        logic        strap;
        logic        ok;
        logic [8:0]  half;   // expected half-period after the write, 0 = bypass
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{32'h01002FFF, 1'b0, 1'b1, 9'd1},
        '{32'h01012FFF, 1'b0, 1'b1, 9'd2},
        '{32'hFFF3FFFF, 1'b0, 1'b1, 9'd8},
        '{32'h01072FFF, 1'b0, 1'b1, 9'd128},
        '{32'h01082FFF, 1'b0, 1'b1, 9'd256},
        '{32'h010A2FFF, 1'b0, 1'b0, 9'd256},
        '{32'h010F2FFF, 1'b0, 1'b0, 9'd256},
        '{32'h010F2FFF, 1'b1, 1'b1, 9'd0},
        '{32'h010E2FFF, 1'b1, 1'b0, 9'd0},
        '{32'h01042FFF, 1'b0, 1'b1, 9'd16},
        '{32'h01052FFF, 1'b0, 1'b1, 9'd32}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        bypass_ok = 1'b0;
    logic        clk_en_o;
    logic        clk_div_o;
    logic        ratio_ok_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    cardclk_div i_cardclk_div (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_wdata_i (cfg_wdata),
        .bypass_ok_i (bypass_ok),
        .clk_en_o    (clk_en_o),
        .clk_div_o   (clk_div_o),
        .ratio_ok_o  (ratio_ok_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] wd, input logic strap);
        @(negedge clk);
        bypass_ok = strap;
        cfg_we    = 1'b1;
        cfg_wdata = wd;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Sync to a rising edge, then measure one high and one low phase
    task automatic measure(input int half, input string req);
        int hi = 0;
        int lo = 0;
        int ticks = 0;
        while (clk_div_o !== 1'b0) @(negedge clk);
        while (clk_div_o !== 1'b1) @(negedge clk);
        while (clk_div_o === 1'b1) begin
            hi++;
            if (clk_en_o === 1'b1) ticks++;
            @(negedge clk);
        end
        while (clk_div_o === 1'b0) begin
            lo++;
            if (clk_en_o === 1'b1) ticks++;
            @(negedge clk);
        end
        check(hi == half, req, "high phase length", hi, half);
        check(lo == half, req, "low phase length", lo, half);
        check(ticks == 1, "R3", "enable pulses per period", ticks, 1);
    endtask

    task automatic measure_bypass();
        int bad = 0;
        for (int k = 0; k < 16; k++) begin
            if (clk_en_o !== 1'b1 || clk_div_o !== 1'b0) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R5", "bypass cycles with wrong outputs", bad, 0);
    endtask

    function automatic string tag_of(input vec_t v);
        if (!v.ok) return "R6";
        if (v.half == 9'd0) return "R5";
        if (v.wd == 32'h01072FFF || v.wd == 32'h01012FFF || v.wd == 32'hFFF3FFFF) return "R4";
        return "R2";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete (all requirements) actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int quiet;
        int hi;
        int lo;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(clk_div_o === 1'b0, "R1", "clk_div_o in reset", int'(clk_div_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(clk_en_o === 1'b0, "R1", "clk_en_o after reset", int'(clk_en_o), 0);
        check(ratio_ok_o === 1'b1, "R1", "ratio_ok_o after reset", int'(ratio_ok_o), 1);
        quiet = 0;
        for (int k = 0; k < 20; k++) begin
            if (clk_div_o !== 1'b0 || clk_en_o !== 1'b0) quiet++;
            @(negedge clk);
        end
        check(quiet == 0, "R1", "activity while never enabled", quiet, 0);

        // Table walk: R2, R4, R5, R6, R7
        for (int i = 0; i < NVEC; i++) begin
            cfg_write(VEC[i].wd, VEC[i].strap);
            check(ratio_ok_o === VEC[i].ok, VEC[i].ok ? "R7" : "R6",
                  "ratio_ok_o after write", int'(ratio_ok_o), int'(VEC[i].ok));
            repeat (600) @(negedge clk);
            if (VEC[i].half == 9'd0) measure_bypass();
            else measure(int'(VEC[i].half), tag_of(VEC[i]));
        end

        // R8: change /512 -> /2 during a high phase
        cfg_write(32'h01082FFF, 1'b0);
        repeat (600) @(negedge clk);
        while (clk_div_o !== 1'b0) @(negedge clk);
        while (clk_div_o !== 1'b1) @(negedge clk);
        hi = 0;
        while (clk_div_o === 1'b1) begin
            hi++;
            if (hi == 10) begin
                cfg_we    = 1'b1;
                cfg_wdata = 32'h01002FFF;
            end else begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0;
        check(hi == 256, "R8", "high phase when ratio changed mid-high", hi, 256);
        lo = 0;
        while (clk_div_o === 1'b0) begin
            lo++;
            @(negedge clk);
        end
        check(lo == 1, "R8", "first low phase at new ratio", lo, 1);
        measure(1, "R8");

        // R9: disable during a /16 high phase
        cfg_write(32'h01032FFF, 1'b0);
        repeat (600) @(negedge clk);
        while (clk_div_o !== 1'b0) @(negedge clk);
        while (clk_div_o !== 1'b1) @(negedge clk);
        hi = 0;
        while (clk_div_o === 1'b1) begin
            hi++;
            if (hi == 3) begin
                cfg_we    = 1'b1;
                cfg_wdata = 32'h00032FFF;
            end else begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0;
        check(hi == 8, "R9", "high phase completed after disable", hi, 8);
        quiet = 0;
        for (int k = 0; k < 40; k++) begin
            if (clk_div_o !== 1'b0 || clk_en_o !== 1'b0) quiet++;
            @(negedge clk);
        end
        check(quiet == 0, "R9", "activity while disabled", quiet, 0);
        cfg_write(32'h01032FFF, 1'b0);
        measure(8, "R9");

        // R1: reset in the middle of a running clock
        cfg_write(32'h01002FFF, 1'b0);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(clk_div_o === 1'b0 && clk_en_o === 1'b0, "R1", "outputs during reset",
              int'({clk_div_o, clk_en_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        quiet = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (clk_div_o !== 1'b0 || clk_en_o !== 1'b0) quiet++;
        end
        check(quiet == 0, "R1", "activity after mid-run reset", quiet, 0);
        check(ratio_ok_o === 1'b1, "R1", "ratio_ok_o after mid-run reset", int'(ratio_ok_o), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule